// File: doc/BRIEF.md
# Floating-Point Store Request Formatter

This block is the execute-stage datapath for a family of floating-point store operations. It takes one decoded store at a time. The decoded store gives the access kind (single precision, double precision or raw integer word), the addressing form (displacement or indexed), an update flag, the base register index and value, the index register value, a 16-bit displacement and the 64-bit floating-point source. From these it builds a single memory write request. The request carries an effective address, a byte count and right-justified store data. Update forms also produce a writeback of the effective address into the base register.

Both edges use a valid/ready handshake. One output register holds the request. While the memory side stalls, the request stays unchanged. The base-register writeback appears only in the cycle the memory side accepts the write. If a decoded store is not a legal form, the block raises an error pulse in place of a request, and neither a write nor a writeback happens.

Top module: `fp_store_fmt`

## Requirements
- R1: In displacement form the address is the base operand plus the 16-bit displacement sign-extended to 64 bits, wrapping modulo 2^64.
- R2: In indexed form the address is the base operand plus the index register value, wrapping modulo 2^64.
- R3: In non-update forms, a base index of 0 makes the base operand zero regardless of the supplied base value.
- R4: Update forms use the supplied base value, and `wb_valid` pulses with `wb_idx` equal to the base index and `wb_data` equal to the address only in a cycle where `mem_valid` and `mem_ready` are both high.
- R5: Kind code 2'b00 (single) writes 4 bytes. `mem_data[31:0]` holds {src[63:62], src[58:29]} when the source exponent field src[62:52] is 0, 2047 or above 896. Bits [63:32] are zero.
- R6: For a single store whose exponent field e lies in 1..896, the word is {sign, 8'h00, frac}. Here frac is ({1, src[51:29]} >> (897-e))[22:0], and frac is zero once the shift reaches 24.
- R7: Kind code 2'b01 (double) writes 8 bytes equal to the source unchanged.
- R8: Kind code 2'b10 (integer word) writes 4 bytes with `mem_data` = {32'h0, src[31:0]}. It is legal only in indexed, non-update form.
- R9: An update form with base index 0 is illegal. So are kind code 2'b11 and an integer word in displacement or update form. Each gives a one-cycle `err_illegal` pulse with no `mem_valid` and no `wb_valid`.
- R10: An accepted store appears on the request outputs in the cycle after acceptance. While `mem_valid` is high and `mem_ready` is low, the request holds stable and `in_ready` is low.
- R11: After reset, `mem_valid`, `wb_valid` and `err_illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded store is present |
| in_ready | output | 1 | Block can take a store this cycle |
| in_kind | input | 2 | 00 single, 01 double, 10 integer word, 11 reserved |
| in_indexed | input | 1 | 1 indexed form, 0 displacement form |
| in_update | input | 1 | Update form: write address back to base |
| in_ra_idx | input | 5 | Base register index |
| in_ra_val | input | 64 | Base register contents |
| in_rb_val | input | 64 | Index register contents |
| in_disp | input | 16 | Signed displacement |
| in_src | input | 64 | Floating-point source register |
| mem_valid | output | 1 | Write request present |
| mem_ready | input | 1 | Memory side accepts the request |
| mem_addr | output | 64 | Effective address |
| mem_nbytes | output | 4 | Byte count, 4 or 8 |
| mem_data | output | 64 | Right-justified store data |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value (effective address) |
| err_illegal | output | 1 | Illegal-form pulse |

## Verification
Request fields and the error pulse are due one clock after the edge that accepts the store. The bench therefore drives each store on a falling edge, lets one rising edge pass, and samples on the next falling edge. The writeback strobe depends on `mem_ready` in the same cycle, so it is sampled in the same half-cycle as the request. During a stall the bench checks it stays low and then rises once `mem_ready` is raised. Stall holding is checked over several consecutive falling edges against the values first captured.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
    parameter int XLEN   = 64;
    parameter int RIDX_W = 5;
    parameter int DISP_W = 16;
    parameter int NB_W   = 4;

    typedef enum logic [1:0] {
        KIND_SINGLE = 2'b00,
        KIND_DOUBLE = 2'b01,
        KIND_IWORD  = 2'b10,
        KIND_RSVD   = 2'b11
    } st_kind_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [XLEN-1:0]   addr;
        logic [NB_W-1:0]   nbytes;
        logic [XLEN-1:0]   data;
        logic              wb_en;
        logic [RIDX_W-1:0] wb_idx;
    } st_req_t;
endpackage

// File: rtl/fpst_agen.sv
module fpst_agen #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int DISP_W = 16
) (
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    input  logic              update,
    output logic [XLEN-1:0]   addr
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] base_op;
    logic [XLEN-1:0] offs_op;

    always_comb begin
        // non-update forms read register 0 as the constant zero
        base_op = (!update && ra_idx == '0) ? '0 : ra_val;
        offs_op = indexed ? rb_val : {{EXT_W{disp[DISP_W-1]}}, disp};
        addr    = base_op + offs_op;
    end
endmodule

// File: rtl/fpst_narrow.sv
module fpst_narrow #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] dbl,
    output logic [31:0]     sgl
);
    localparam logic [10:0] EXP_MAX  = 11'h7FF;
    localparam logic [10:0] EXP_TINY = 11'd896;
    localparam logic [10:0] EXP_DEN  = 11'd897;

    logic [10:0] expo;
    logic [10:0] shamt;
    logic [23:0] mant;
    logic [23:0] shifted;
    logic [22:0] frac;

    always_comb begin
        expo    = dbl[62:52];
        shamt   = EXP_DEN - expo;
        mant    = {1'b1, dbl[51:29]};
        shifted = mant >> shamt[4:0];
        frac    = (shamt >= 11'd24) ? '0 : shifted[22:0];
        if (expo > EXP_TINY || expo == '0 || expo == EXP_MAX) begin
            sgl = {dbl[63:62], dbl[58:29]};
        end else begin
            sgl = {dbl[63], 8'h00, frac};
        end
    end
endmodule

// File: rtl/fp_store_fmt.sv
module fp_store_fmt
    import fpst_pkg::*;
#(
    parameter int AW  = fpst_pkg::XLEN,
    parameter int RW  = fpst_pkg::RIDX_W,
    parameter int DW  = fpst_pkg::DISP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_kind,
    input  logic          in_indexed,
    input  logic          in_update,
    input  logic [RW-1:0] in_ra_idx,
    input  logic [AW-1:0] in_ra_val,
    input  logic [AW-1:0] in_rb_val,
    input  logic [DW-1:0] in_disp,
    input  logic [AW-1:0] in_src,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_nbytes,
    output logic [AW-1:0] mem_data,
    output logic          wb_valid,
    output logic [RW-1:0] wb_idx,
    output logic [AW-1:0] wb_data,
    output logic          err_illegal
);
    localparam int HALF = AW / 2;

    st_req_t  req_d, req_q;
    st_kind_e kind;
    logic [AW-1:0] ea;
    logic [31:0]   sgl_word;
    logic          bad_form;
    logic          take;

    fpst_agen #(.XLEN(AW), .RIDX_W(RW), .DISP_W(DW)) u_agen (
        .ra_idx  (in_ra_idx),
        .ra_val  (in_ra_val),
        .rb_val  (in_rb_val),
        .disp    (in_disp),
        .indexed (in_indexed),
        .update  (in_update),
        .addr    (ea)
    );

    fpst_narrow #(.XLEN(AW)) u_narrow (
        .dbl (in_src),
        .sgl (sgl_word)
    );

    always_comb begin
        kind     = st_kind_e'(in_kind);
        in_ready = !req_q.valid || req_q.illegal || mem_ready;
        take     = in_valid && in_ready;
        bad_form = (in_update && in_ra_idx == '0)
                 || (kind == KIND_RSVD)
                 || (kind == KIND_IWORD && (!in_indexed || in_update));

        req_d = req_q;
        if (take) begin
            req_d.valid   = 1'b1;
            req_d.illegal = bad_form;
            req_d.addr    = ea;
            req_d.wb_en   = in_update && !bad_form;
            req_d.wb_idx  = in_ra_idx;
            unique case (kind)
                KIND_DOUBLE: begin
                    req_d.nbytes = 4'd8;
                    req_d.data   = in_src;
                end
                KIND_IWORD: begin
                    req_d.nbytes = 4'd4;
                    req_d.data   = {{HALF{1'b0}}, in_src[HALF-1:0]};
                end
                default: begin
                    req_d.nbytes = 4'd4;
                    req_d.data   = {{(AW-32){1'b0}}, sgl_word};
                end
            endcase
        end else if (req_q.valid && (req_q.illegal || mem_ready)) begin
            req_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    always_comb begin
        mem_valid   = req_q.valid && !req_q.illegal;
        err_illegal = req_q.valid && req_q.illegal;
        mem_addr    = req_q.addr;
        mem_nbytes  = req_q.nbytes;
        mem_data    = req_q.data;
        wb_valid    = mem_valid && mem_ready && req_q.wb_en;
        wb_idx      = req_q.wb_idx;
        wb_data     = req_q.addr;
    end

    // R10: a stalled request keeps every field
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_data) && $stable(mem_nbytes));

    // R10: input side blocked only by a stalled request
    p_ready_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> mem_valid && !mem_ready);

    // R4: writeback only alongside an accepted write
    p_wb_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> mem_valid && mem_ready && wb_data == mem_addr);

    // R9: an illegal form never writes or updates, and lasts one cycle
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> !mem_valid && !wb_valid);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal && !in_valid |=> !err_illegal);

    // R5 R7 R8: byte count is always one of the two sizes
    p_nbytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_nbytes == 4'd4 || mem_nbytes == 4'd8);

    // R5: a 4-byte write leaves the upper half clear
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_nbytes == 4'd4 |-> mem_data[AW-1:HALF] == '0);
endmodule

// File: tb/sim_fp_store_fmt.sv
module sim_fp_store_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = '0;
    logic        in_indexed = 1'b0;
    logic        in_update = 1'b0;
    logic [4:0]  in_ra_idx = '0;
    logic [63:0] in_ra_val = '0;
    logic [63:0] in_rb_val = '0;
    logic [15:0] in_disp = '0;
    logic [63:0] in_src = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [3:0]  mem_nbytes;
    logic [63:0] mem_data;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        err_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fp_store_fmt u0 (.*);

    typedef struct packed {
        logic [7:0]  rq;
        logic [1:0]  kind;
        logic        idx;
        logic        upd;
        logic [4:0]  ra_idx;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [15:0] disp;
        logic [63:0] src;
        logic [63:0] e_addr;
        logic [3:0]  e_n;
        logic [63:0] e_data;
        logic        e_wb;
        logic        e_err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // R1 R5: negative displacement, 1.0 narrowed
        '{8'd1, 2'b00, 1'b0, 1'b0, 5'd3, 64'h1000, 64'h0, 16'hFFF0, 64'h3FF0000000000000, 64'hFF0, 4'd4, 64'h3F800000, 1'b0, 1'b0},
        // R2 R7: indexed double
        '{8'd7, 2'b01, 1'b1, 1'b0, 5'd4, 64'h2000, 64'h18, 16'h0, 64'h123456789ABCDEF0, 64'h2018, 4'd8, 64'h123456789ABCDEF0, 1'b0, 1'b0},
        // R3: base index 0 reads as zero, -2.0 narrowed
        '{8'd3, 2'b00, 1'b0, 1'b0, 5'd0, 64'hDEAD, 64'h0, 16'h0008, 64'hC000000000000000, 64'h8, 4'd8 - 4'd4, 64'hC0000000, 1'b0, 1'b0},
        // R4 R1: update with wrap around 2^64
        '{8'd4, 2'b01, 1'b0, 1'b1, 5'd7, 64'hFFFFFFFFFFFFFFF8, 64'h0, 16'h0010, 64'h5555, 64'h8, 4'd8, 64'h5555, 1'b1, 1'b0},
        // R8 R3: integer word, low half stored
        '{8'd8, 2'b10, 1'b1, 1'b0, 5'd0, 64'd99, 64'h40, 16'h0, 64'hAAAABBBBCCCCDDDD, 64'h40, 4'd4, 64'hCCCCDDDD, 1'b0, 1'b0},
        // R6 R4: exponent 896 gives denormal, indexed update
        '{8'd6, 2'b00, 1'b1, 1'b1, 5'd2, 64'h100, 64'h4, 16'h0, 64'h3800000000000000, 64'h104, 4'd4, 64'h00400000, 1'b1, 1'b0},
        // R6: exponent 895 gives a further shift
        '{8'd6, 2'b00, 1'b0, 1'b0, 5'd1, 64'h10, 64'h0, 16'h0, 64'h37F0000000000000, 64'h10, 4'd4, 64'h00200000, 1'b0, 1'b0},
        // R5: infinity keeps its pattern
        '{8'd5, 2'b00, 1'b1, 1'b0, 5'd1, 64'h10, 64'h10, 16'h0, 64'h7FF0000000000000, 64'h20, 4'd4, 64'h7F800000, 1'b0, 1'b0},
        // R9: update with base index 0
        '{8'd9, 2'b01, 1'b0, 1'b1, 5'd0, 64'h10, 64'h0, 16'h4, 64'h1, 64'h0, 4'd0, 64'h0, 1'b0, 1'b1},
        // R9 R8: integer word in displacement form
        '{8'd9, 2'b10, 1'b0, 1'b0, 5'd1, 64'h10, 64'h0, 16'h4, 64'h1, 64'h0, 4'd0, 64'h0, 1'b0, 1'b1},
        // R9: reserved kind
        '{8'd9, 2'b11, 1'b1, 1'b0, 5'd1, 64'h10, 64'h8, 16'h0, 64'h1, 64'h0, 4'd0, 64'h0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_kind    = v.kind;
        in_indexed = v.idx;
        in_update  = v.upd;
        in_ra_idx  = v.ra_idx;
        in_ra_val  = v.ra;
        in_rb_val  = v.rb;
        in_disp    = v.disp;
        in_src     = v.src;
        in_valid   = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] held_addr;
        logic [63:0] held_data;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 mem_valid", 64'(mem_valid), 64'd0);
        check("R11 wb_valid", 64'(wb_valid), 64'd0);
        check("R11 err_illegal", 64'(err_illegal), 64'd0);
        check("R11 in_ready", 64'(in_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            string t;
            drive(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            t = $sformatf("R%0d vec%0d", VEC[i].rq, i);
            check({t, " mem_valid"}, 64'(mem_valid), 64'(!VEC[i].e_err));
            check({t, " err"}, 64'(err_illegal), 64'(VEC[i].e_err));
            check({t, " wb_valid"}, 64'(wb_valid), 64'(VEC[i].e_wb));
            if (!VEC[i].e_err) begin
                check({t, " addr"}, mem_addr, VEC[i].e_addr);
                check({t, " nbytes"}, 64'(mem_nbytes), 64'(VEC[i].e_n));
                check({t, " data"}, mem_data, VEC[i].e_data);
            end
            if (VEC[i].e_wb) begin
                check({t, " wb_idx"}, 64'(wb_idx), 64'(VEC[i].ra_idx));
                check({t, " wb_data"}, wb_data, VEC[i].e_addr);
            end
        end
        @(negedge clk);
        check("R9 err one cycle", 64'(err_illegal), 64'd0);

        // R10 R4: stall an update store
        mem_ready = 1'b0;
        drive(VEC[3]);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        held_addr = mem_addr;
        held_data = mem_data;
        check("R10 valid after accept", 64'(mem_valid), 64'd1);
        check("R10 in_ready low", 64'(in_ready), 64'd0);
        check("R4 no early writeback", 64'(wb_valid), 64'd0);
        // offer another store during the stall: it must not be taken
        drive(VEC[1]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 addr held", mem_addr, held_addr);
            check("R10 data held", mem_data, held_data);
            check("R4 writeback held off", 64'(wb_valid), 64'd0);
        end
        in_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        check("R4 writeback on accept", 64'(wb_valid), 64'd1);
        check("R4 writeback value", wb_data, 64'h8);
        @(negedge clk);
        check("R10 drained", 64'(mem_valid), 64'd0);
        check("R4 no second writeback", 64'(wb_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule